// File: doc/BRIEF.md
# Triggered Reload Down-Counter Timer

This block is a down-counting timer governed by a four-state controller: stopped, armed and waiting for a trigger, loading, and running. Software drives it through a simple set of register strobes. One control write carries an enable bit, a one-shot trigger strobe, a reload-mode select, an initial output level and an underflow-flag clear. A separate strobe writes the reload value. A trigger can come from software or from a rising edge on an asynchronous input pin. Every trigger passes through a single load cycle that copies the reload value into the counter before counting begins.

The counter decrements once for each cycle in which the count-tick input is high. When a tick arrives with the counter at zero, an underflow occurs. The underflow sets a sticky flag and toggles the timer output. The controller then either reloads and keeps running (reload mode), or falls back to waiting for the next trigger (one-shot mode). The state also gates the pins. While stopped, the trigger pin is ignored and the output pin carries a plain port level supplied by the surrounding logic. While armed, the output holds its programmed initial level. While running, the output is the toggling timer waveform.

Top module: `trig_reload_timer`

## Requirements
- R1: After reset the state output reads 0, the counter reads 0, the underflow flag is 0 and `timer_out` equals `port_level`. State codes are STOP=0, WAIT=1, LOAD=2, RUN=3.
- R2: A control write with enable=1 moves the state from STOP to WAIT when trigger=0, or to LOAD when trigger=1. A control write with enable=0 moves any state to STOP on the next cycle. Disable has the highest priority of all transitions.
- R3: In WAIT, a control write with enable=1 and trigger=1, or a rising edge on `trig_pin`, moves the state to LOAD. The pin passes through two synchronizer flops and an edge detector, so a pin rise set up before clock edge 1 shows as LOAD after clock edge 3.
- R4: LOAD lasts exactly one cycle (unless disabled). It copies the reload register into the counter and is followed by RUN.
- R5: In RUN the counter decreases by one on each cycle with `count_tick`=1 and holds when `count_tick`=0. In STOP and WAIT the counter holds its value.
- R6: A tick in RUN with the counter at 0 is an underflow. The counter wraps to all ones and the flag sets. The flag stays set until a control write with the flag bit 0. A simultaneous underflow wins over a clear. Writing the flag bit as 1 leaves the flag unchanged.
- R7: On underflow the state goes to LOAD when reload mode (bit = 1) is in effect, and to WAIT when it is 0.
- R8: In RUN, a software trigger or a synchronized pin rising edge restarts the count through LOAD. Triggers take priority over underflow.
- R9: Pin edges occurring in STOP have no effect, either at the time or after a later enable into WAIT.
- R10: `timer_out` equals `port_level` in STOP and the internal level otherwise. The level is set to the initial level in effect after the write when the state leaves STOP or enters WAIT. Otherwise it toggles on each underflow.
- R11: A reload-register write does not disturb the counter. It takes effect at the next LOAD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_enable | input | 1 | Count-enable value written |
| cfg_trigger | input | 1 | Software trigger strobe (not stored) |
| cfg_reload | input | 1 | 1 = reload mode, 0 = one-shot |
| cfg_init_level | input | 1 | Output level applied when armed |
| cfg_flag | input | 1 | 0 clears the underflow flag, 1 leaves it |
| rld_we | input | 1 | Reload register write strobe |
| rld_data | input | CNT_W | Reload value |
| count_tick | input | 1 | Count enable for this cycle |
| trig_pin | input | 1 | Asynchronous external trigger |
| port_level | input | 1 | Plain port level used while stopped |
| timer_out | output | 1 | Timer output pin |
| state_o | output | 2 | Controller state code |
| count_o | output | CNT_W | Counter value |
| uf_flag_o | output | 1 | Sticky underflow flag |

## Verification
The bench targets several corner cases:
- The exact three-edge latency from a pin rise to LOAD. A missing or extra synchronizer stage would shift it by a cycle.
- A pin edge while stopped. A design that latched it would jump from WAIT straight to LOAD after enabling.
- Underflow colliding with a flag clear, a software trigger or a disable. Wrong priorities would leave the flag cleared, skip the restart, or keep running after the disable.
- The forced initial level on entry to WAIT after a one-shot underflow. A design that got it wrong would leave the toggled level on the pin.
- Reload writes during RUN. A design that loaded them at once would corrupt the running count.

// File: rtl/trt_pkg.sv
package trt_pkg;

    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_WAIT = 2'd1,
        ST_LOAD = 2'd2,
        ST_RUN  = 2'd3
    } trt_state_e;

    typedef struct packed {
        trt_state_e st;
        logic       mode;
        logic       init;
        logic       flag;
        logic       lvl;
    } trt_ctl_t;

    localparam trt_ctl_t CTL_RESET = '{st: ST_STOP, mode: 1'b0, init: 1'b0, flag: 1'b0, lvl: 1'b0};

endpackage

// File: rtl/trt_sync.sv
module trt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain_q, chain_d;
    logic         last_q, last_d;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = pin_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[TOP-1:0], pin_i};
        end
    endgenerate

    always_comb begin
        last_d = chain_q[TOP];
        rise_o = chain_q[TOP] & ~last_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= chain_d;
            last_q  <= last_d;
        end
    end
endmodule

// File: rtl/trt_ctrl.sv
module trt_ctrl
    import trt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic       wr_enable,
    input  logic       wr_trigger,
    input  logic       wr_mode,
    input  logic       wr_init,
    input  logic       wr_flag,
    input  logic       ext_rise,
    input  logic       uf_i,
    output trt_state_e state_o,
    output logic       mode_o,
    output logic       flag_o,
    output logic       lvl_o
);
    trt_ctl_t ctl_q, ctl_d;
    logic     stop_req, sw_trig, any_trig;

    always_comb begin
        ctl_d    = ctl_q;
        stop_req = cfg_we & ~wr_enable;
        sw_trig  = cfg_we & wr_enable & wr_trigger;
        any_trig = sw_trig | ext_rise;

        if (cfg_we) begin
            ctl_d.mode = wr_mode;
            ctl_d.init = wr_init;
        end

        unique case (ctl_q.st)
            ST_STOP: begin
                if (cfg_we && wr_enable)
                    ctl_d.st = wr_trigger ? ST_LOAD : ST_WAIT;
            end
            ST_WAIT: begin
                if (any_trig) ctl_d.st = ST_LOAD;
            end
            ST_LOAD: begin
                ctl_d.st = ST_RUN;
            end
            ST_RUN: begin
                if (any_trig)  ctl_d.st = ST_LOAD;
                else if (uf_i) ctl_d.st = ctl_q.mode ? ST_LOAD : ST_WAIT;
            end
            default: ctl_d.st = ST_STOP;
        endcase

        if (stop_req) ctl_d.st = ST_STOP;

        if (uf_i)                   ctl_d.flag = 1'b1;
        else if (cfg_we && !wr_flag) ctl_d.flag = 1'b0;

        if ((ctl_d.st == ST_WAIT && ctl_q.st != ST_WAIT) ||
            (ctl_q.st == ST_STOP && ctl_d.st != ST_STOP))
            ctl_d.lvl = ctl_d.init;
        else if (uf_i)
            ctl_d.lvl = ~ctl_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RESET;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        state_o = ctl_q.st;
        mode_o  = ctl_q.mode;
        flag_o  = ctl_q.flag;
        lvl_o   = ctl_q.lvl;
    end
endmodule

// File: rtl/trt_count.sv
module trt_count
    import trt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  trt_state_e   state_i,
    input  logic         tick_i,
    input  logic         rld_we,
    input  logic [W-1:0] rld_data,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] rld_o,
    output logic         uf_o
);
    localparam logic [W-1:0] ZERO = '0;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] rld;
    } cnt_regs_t;

    cnt_regs_t r_q, r_d;
    logic      dec;

    always_comb begin
        r_d  = r_q;
        dec  = (state_i == ST_RUN) && tick_i;
        uf_o = dec && (r_q.cnt == ZERO);

        if (rld_we) r_d.rld = rld_data;

        if (state_i == ST_LOAD) r_d.cnt = r_q.rld;
        else if (dec)           r_d.cnt = r_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{cnt: ZERO, rld: ZERO};
        else        r_q <= r_d;
    end

    always_comb begin
        cnt_o = r_q.cnt;
        rld_o = r_q.rld;
    end
endmodule

// File: rtl/trig_reload_timer.sv
module trig_reload_timer
    import trt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_enable,
    input  logic             cfg_trigger,
    input  logic             cfg_reload,
    input  logic             cfg_init_level,
    input  logic             cfg_flag,
    input  logic             rld_we,
    input  logic [CNT_W-1:0] rld_data,
    input  logic             count_tick,
    input  logic             trig_pin,
    input  logic             port_level,
    output logic             timer_out,
    output logic [1:0]       state_o,
    output logic [CNT_W-1:0] count_o,
    output logic             uf_flag_o
);
    trt_state_e       st_w;
    logic             rise_w, uf_w, mode_w, lvl_w;
    logic [CNT_W-1:0] rld_w;

    trt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (trig_pin),
        .rise_o (rise_w)
    );

    trt_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .wr_enable  (cfg_enable),
        .wr_trigger (cfg_trigger),
        .wr_mode    (cfg_reload),
        .wr_init    (cfg_init_level),
        .wr_flag    (cfg_flag),
        .ext_rise   (rise_w),
        .uf_i       (uf_w),
        .state_o    (st_w),
        .mode_o     (mode_w),
        .flag_o     (uf_flag_o),
        .lvl_o      (lvl_w)
    );

    trt_count #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_i  (st_w),
        .tick_i   (count_tick),
        .rld_we   (rld_we),
        .rld_data (rld_data),
        .cnt_o    (count_o),
        .rld_o    (rld_w),
        .uf_o     (uf_w)
    );

    always_comb begin
        state_o   = st_w;
        timer_out = (st_w == ST_STOP) ? port_level : lvl_w;
    end
endmodule

// File: rtl/trig_reload_timer_chk.sv
module trig_reload_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic             cfg_enable,
    input logic             cfg_flag,
    input logic             count_tick,
    input logic [1:0]       state_o,
    input logic [CNT_W-1:0] count_o,
    input logic [CNT_W-1:0] rld_w,
    input logic             mode_w,
    input logic             uf_flag_o,
    input logic             timer_out
);
    logic at_zero_tick;
    always_comb at_zero_tick = (state_o == 2'd3) && count_tick && (count_o == '0);

    // R2
    disable_to_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && !cfg_enable |=> state_o == 2'd0);

    // R4
    load_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 2'd2 && !(cfg_we && !cfg_enable) |=> state_o == 2'd3);

    // R4
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 2'd2 |=> count_o == $past(rld_w));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 2'd0 || state_o == 2'd1 |=> $stable(count_o));

    // R5
    run_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 2'd3 && count_tick && count_o != '0 |=> count_o == $past(count_o) - 1'b1);

    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        at_zero_tick |=> uf_flag_o);

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uf_flag_o && !(cfg_we && !cfg_flag) |=> uf_flag_o);

    // R7
    reload_again_chk: assert property (@(posedge clk) disable iff (!rst_n)
        at_zero_tick && mode_w && !cfg_we |=> state_o == 2'd2);

    // R10
    uf_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        at_zero_tick && mode_w && !cfg_we |=> timer_out != $past(timer_out));
endmodule

bind trig_reload_timer trig_reload_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_enable (cfg_enable),
    .cfg_flag   (cfg_flag),
    .count_tick (count_tick),
    .state_o    (state_o),
    .count_o    (count_o),
    .rld_w      (rld_w),
    .mode_w     (mode_w),
    .uf_flag_o  (uf_flag_o),
    .timer_out  (timer_out)
);

// File: tb/trig_reload_timer_bench.sv
`timescale 1ns/1ps
module trig_reload_timer_bench;
    localparam int W = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic         rst_n, cfg_we, cfg_enable, cfg_trigger, cfg_reload, cfg_init_level, cfg_flag;
    logic         rld_we, count_tick, trig_pin, port_level;
    logic [W-1:0] rld_data;
    logic         timer_out, uf_flag_o;
    logic [1:0]   state_o;
    logic [W-1:0] count_o;

    trig_reload_timer #(.CNT_W(W)) u_trig_reload_timer (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_enable(cfg_enable),
        .cfg_trigger(cfg_trigger), .cfg_reload(cfg_reload), .cfg_init_level(cfg_init_level),
        .cfg_flag(cfg_flag), .rld_we(rld_we), .rld_data(rld_data), .count_tick(count_tick),
        .trig_pin(trig_pin), .port_level(port_level), .timer_out(timer_out),
        .state_o(state_o), .count_o(count_o), .uf_flag_o(uf_flag_o)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int           m_st;
    logic [W-1:0] m_cnt, m_rld;
    logic         m_flag, m_lvl, m_mode, m_init, m_s1, m_s2, m_prev;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_st = 0; m_cnt = '0; m_rld = '0; m_flag = 0; m_lvl = 0;
        m_mode = 0; m_init = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
    endtask

    task automatic model_edge();
        bit dis, swt, edge_seen, uf;
        int nst;
        logic n_mode, n_init;
        dis  = cfg_we && !cfg_enable;
        swt  = cfg_we && cfg_enable && cfg_trigger;
        edge_seen = m_s2 && !m_prev;
        uf   = (m_st == 3) && count_tick && (m_cnt == '0);
        n_mode = cfg_we ? cfg_reload : m_mode;
        n_init = cfg_we ? cfg_init_level : m_init;
        nst  = m_st;
        case (m_st)
            0: if (cfg_we && cfg_enable) nst = cfg_trigger ? 2 : 1;
            1: if (swt || edge_seen) nst = 2;
            2: nst = 3;
            default: if (swt || edge_seen) nst = 2; else if (uf) nst = m_mode ? 2 : 1;
        endcase
        if (dis) nst = 0;
        if (m_st == 2) m_cnt = m_rld;
        else if (m_st == 3 && count_tick) m_cnt = m_cnt - 1'b1;
        if (uf) m_flag = 1;
        else if (cfg_we && !cfg_flag) m_flag = 0;
        if ((nst == 1 && m_st != 1) || (m_st == 0 && nst != 0)) m_lvl = n_init;
        else if (uf) m_lvl = ~m_lvl;
        if (rld_we) m_rld = rld_data;
        m_prev = m_s2; m_s2 = m_s1; m_s1 = trig_pin;
        m_mode = n_mode; m_init = n_init; m_st = nst;
    endtask

    task automatic compare(string req);
        chk(req, "state", {30'd0, state_o}, m_st);
        chk(req, "count", {16'd0, count_o}, {16'd0, m_cnt});
        chk(req, "flag", {31'd0, uf_flag_o}, {31'd0, m_flag});
        chk(req, "out", {31'd0, timer_out}, {31'd0, (m_st == 0) ? port_level : m_lvl});
    endtask

    task automatic step(string req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(req);
    endtask

    task automatic wr_cfg(bit en, bit trg, bit md, bit il, bit fl, string req);
        cfg_we = 1; cfg_enable = en; cfg_trigger = trg; cfg_reload = md;
        cfg_init_level = il; cfg_flag = fl;
        step(req);
        cfg_we = 0; cfg_trigger = 0;
    endtask

    initial begin
        rst_n = 0; cfg_we = 0; cfg_enable = 0; cfg_trigger = 0; cfg_reload = 0;
        cfg_init_level = 0; cfg_flag = 1; rld_we = 0; rld_data = '0;
        count_tick = 1; trig_pin = 0; port_level = 1;
        model_reset();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "state", {30'd0, state_o}, 0);
        chk("R1", "count", {16'd0, count_o}, 0);
        chk("R1", "flag", {31'd0, uf_flag_o}, 0);
        chk("R1", "out", {31'd0, timer_out}, 1);
        rst_n = 1;
        step("R1");

        // R11 reload write
        rld_we = 1; rld_data = 16'd3; step("R11"); rld_we = 0;
        // R2 enable without trigger -> WAIT, R10 init level 0 on pin
        wr_cfg(1, 0, 1, 0, 1, "R2");
        chk("R2", "wait", {30'd0, state_o}, 1);
        chk("R10", "init", {31'd0, timer_out}, 0);
        repeat (2) step("R5");
        // R3 pin edge latency
        trig_pin = 1;
        step("R3"); step("R3"); step("R3");
        chk("R3", "load after 3 edges", {30'd0, state_o}, 2);
        step("R4");
        chk("R4", "loaded", {16'd0, count_o}, 3);
        // R7 reload mode runs through several underflows
        repeat (6) step("R7");
        rld_we = 1; rld_data = 16'd5; step("R11"); rld_we = 0;
        repeat (8) step("R11");
        // R8 software restart in RUN
        wr_cfg(1, 1, 1, 0, 1, "R8");
        chk("R8", "restart", {30'd0, state_o}, 2);
        step("R8");
        // R6 flag clear
        wr_cfg(1, 0, 1, 0, 0, "R6");
        chk("R6", "cleared", {31'd0, uf_flag_o}, 0);
        // R7 one-shot, R10 initial level forced on WAIT entry
        wr_cfg(1, 0, 0, 1, 1, "R7");
        repeat (8) step("R7");
        chk("R7", "one-shot wait", {30'd0, state_o}, 1);
        chk("R10", "wait level", {31'd0, timer_out}, 1);
        // R2 disable
        port_level = 0;
        wr_cfg(0, 0, 0, 1, 1, "R2");
        chk("R2", "stop", {30'd0, state_o}, 0);
        // R9 pin edge while stopped ignored
        trig_pin = 0; repeat (4) step("R9");
        trig_pin = 1; repeat (5) step("R9");
        chk("R9", "still stop", {30'd0, state_o}, 0);
        wr_cfg(1, 0, 1, 0, 1, "R9");
        repeat (4) step("R9");
        chk("R9", "still wait", {30'd0, state_o}, 1);
        // R5 hold when tick low
        wr_cfg(1, 1, 1, 0, 1, "R5");
        step("R5");
        count_tick = 0;
        repeat (4) step("R5");
        chk("R5", "hold", {16'd0, count_o}, 5);
        count_tick = 1;

        // random mix
        void'($urandom(32'h5eed));
        for (int i = 0; i < 4000; i++) begin
            cfg_we         = ($urandom_range(15) == 0);
            cfg_enable     = ($urandom_range(7) != 0);
            cfg_trigger    = ($urandom_range(3) == 0);
            cfg_reload     = $urandom_range(1);
            cfg_init_level = $urandom_range(1);
            cfg_flag       = ($urandom_range(3) != 0);
            rld_we         = ($urandom_range(31) == 0);
            rld_data       = 16'($urandom_range(7));
            count_tick     = ($urandom_range(3) != 0);
            if ($urandom_range(7) == 0) trig_pin = ~trig_pin;
            if ($urandom_range(15) == 0) port_level = ~port_level;
            step("R8");
        end
        cfg_we = 0; rld_we = 0;

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule